// File: doc/BRIEF.md
# Four-Row Character Display Position Writer

This block places a single character at a chosen row and column of a four-row character display that is driven over an 8-bit parallel bus. A request carries a row, a column, a character code and a row-width selection. The block turns the position into a display-memory address and then runs a fixed sequence of bus transactions. It writes the set-address instruction and polls the status byte until the busy bit clears. It then writes the character code and polls again, so the display is idle when the next request starts.

Rows 2 and 3 of the narrow layouts sit inside the same memory lines as rows 0 and 1, offset by 20 locations. The 40-column layout uses two display controllers. Each controller holds two rows and has its own enable strobe, and every transaction of a request goes to the controller that owns the row. Each bus transaction sets up the register-select and read/write lines for one clock. It then holds the enable high for `E_HIGH_CLKS` clocks and keeps all lines steady for one clock after the enable falls.

Sequencer states: `S_IDLE` (ready for a request), `S_SET_ADDR` (address instruction), `S_POLL_ADDR` (status poll after the address), `S_PUT_CHAR` (character write), `S_POLL_CHAR` (status poll after the character) and `S_FINISH` (completion pulse). The transitions are as follows. `S_IDLE`→`S_SET_ADDR` on an accepted, valid request. `S_SET_ADDR`→`S_POLL_ADDR` when the transaction ends. `S_POLL_ADDR`→`S_POLL_ADDR` while the busy bit reads 1, and `S_POLL_ADDR`→`S_PUT_CHAR` when it reads 0. `S_PUT_CHAR`→`S_POLL_CHAR` when the transaction ends. `S_POLL_CHAR`→`S_POLL_CHAR` while busy, and `S_POLL_CHAR`→`S_FINISH` when not busy. `S_FINISH`→`S_IDLE` always. A rejected request keeps the sequencer in `S_IDLE`. The bus engine has its own states: `BUS_IDLE`, `BUS_SETUP`, `BUS_PULSE` and `BUS_HOLD`.

Top module: `lcd_pos_writer`

## Requirements
- R1: With `width_sel` 0 (16 columns) or 1 (20 columns), the target address is the row base plus the column. The row bases are 0x00 for row 0, 0x40 for row 1, 0x14 for row 2 and 0x54 for row 3. Every transaction of the request strobes `lcd_en0`.
- R2: With `width_sel` 2 (40 columns), rows 0 and 1 use bases 0x00 and 0x40 and strobe `lcd_en0`. Rows 2 and 3 use bases 0x00 and 0x40 and strobe `lcd_en1`. The two enables are never high together.
- R3: The first transaction of a request is an instruction write: `lcd_rs`=0, `lcd_rw`=0 and `lcd_dout` = 0x80 | address.
- R4: A status poll is a read with `lcd_rs`=0 and `lcd_rw`=1. The busy bit is `lcd_din[7]`, and bits 6..0 carry the address counter. Polls repeat while the busy bit is 1. One poll sequence follows the address write and one follows the character write. The character is written only after a poll returns 0.
- R5: The character write uses `lcd_rs`=1, `lcd_rw`=0 and `lcd_dout` = the requested character.
- R6: In each transaction, `lcd_rs`, `lcd_rw` and `lcd_dout` are set at least one clock before the enable rises. The enable stays high for exactly `E_HIGH_CLKS` clocks. All three lines stay unchanged in the clock after the enable falls. `lcd_doe` is 1 only during write transactions.
- R7: A request is rejected if the row is above 3, if the column is at or above the selected width, or if `width_sel` is 3. A rejected request gives a one-clock `req_err` pulse in the clock after acceptance and causes no enable activity.
- R8: `req_ready` is 1 only in `S_IDLE`. `op_done` pulses for one clock, N·(`E_HIGH_CLKS`+3) clocks after the accepting edge, where N is the number of bus transactions the request used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_row | input | ROW_W | Target row (0..3 valid) |
| req_col | input | COL_W | Target column |
| req_char | input | 8 | Character code to write |
| width_sel | input | 2 | 0: 16 columns, 1: 20, 2: 40, 3: reserved |
| req_err | output | 1 | One-clock pulse for a rejected request |
| op_done | output | 1 | One-clock pulse when a request completes |
| lcd_rs | output | 1 | Register select (0 instruction/status, 1 data) |
| lcd_rw | output | 1 | 1 read, 0 write |
| lcd_en0 | output | 1 | Enable strobe, first controller |
| lcd_en1 | output | 1 | Enable strobe, second controller |
| lcd_dout | output | 8 | Data driven onto the bus |
| lcd_doe | output | 1 | Bus drive enable for `lcd_dout` |
| lcd_din | input | 8 | Data read from the bus |

## Verification
Each bus transaction takes `E_HIGH_CLKS`+3 clocks from launch to the next launch. The bench therefore expects `op_done` exactly N·(`E_HIGH_CLKS`+3) clocks after the accepting edge, and it counts falling clock edges from that point to check this. A rejected request must show `req_err` at the first falling edge after acceptance and nothing on the enables afterwards. A bench-side display model records every enable pulse at the falling clock edge in its hold clock, where lines are guaranteed stable, and returns programmed busy counts. The recorded transaction list is then compared entry by entry with the list computed from R1–R5.

// File: rtl/lcd_pos_pkg.sv
package lcd_pos_pkg;

    typedef enum logic [1:0] {
        WID_16  = 2'd0,
        WID_20  = 2'd1,
        WID_40  = 2'd2,
        WID_RSV = 2'd3
    } row_width_e;

    localparam int unsigned DISP_AW       = 7;
    localparam logic [6:0]  LINE_B_BASE   = 7'h40;
    localparam logic [6:0]  NARROW_SHIFT  = 7'h14;
    localparam logic [7:0]  SET_ADDR_OP   = 8'h80;

    function automatic logic [6:0] cols_of(input row_width_e w);
        unique case (w)
            WID_16:  cols_of = 7'd16;
            WID_20:  cols_of = 7'd20;
            WID_40:  cols_of = 7'd40;
            default: cols_of = 7'd0;
        endcase
    endfunction

endpackage

// File: rtl/lcd_addr_map.sv
module lcd_addr_map
    import lcd_pos_pkg::*;
#(
    parameter int unsigned ROW_W = 3,
    parameter int unsigned COL_W = 6
) (
    input  logic [ROW_W-1:0]   row,
    input  logic [COL_W-1:0]   col,
    input  logic [1:0]         wsel,
    output logic               pos_ok,
    output logic [DISP_AW-1:0] addr,
    output logic               ctl_sel
);
    localparam int unsigned EXT_W = (COL_W > DISP_AW) ? COL_W : DISP_AW;

    row_width_e          wmode;
    logic [EXT_W-1:0]    col_ext;
    logic [EXT_W-1:0]    lim_ext;
    logic                row_ok;
    logic [DISP_AW-1:0]  base;

    assign wmode   = row_width_e'(wsel);
    assign col_ext = EXT_W'(col);
    assign lim_ext = EXT_W'(cols_of(wmode));

    generate
        if (ROW_W > 2) begin : g_row_hi
            assign row_ok = (row[ROW_W-1:2] == '0);
        end else begin : g_row_fit
            assign row_ok = 1'b1;
        end
    endgenerate

    always_comb begin
        base    = row[0] ? LINE_B_BASE : '0;
        ctl_sel = 1'b0;
        if (wmode == WID_40) begin
            ctl_sel = row[1];
        end else if (row[1]) begin
            base = base + NARROW_SHIFT;
        end
        addr   = base + DISP_AW'(col);
        pos_ok = row_ok && (wmode != WID_RSV) && (col_ext < lim_ext);
    end

endmodule

// File: rtl/lcd_bus_engine.sv
module lcd_bus_engine #(
    parameter int unsigned E_HIGH_CLKS = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       cmd_rs,
    input  logic       cmd_rw,
    input  logic [7:0] cmd_data,
    input  logic       cmd_ctl,
    output logic       done,
    output logic [7:0] rd_data,
    output logic       bus_rs,
    output logic       bus_rw,
    output logic       bus_e0,
    output logic       bus_e1,
    output logic [7:0] bus_dout,
    output logic       bus_doe,
    input  logic [7:0] bus_din
);
    localparam int unsigned CW = (E_HIGH_CLKS < 2) ? 1 : $clog2(E_HIGH_CLKS + 1);

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_SETUP,
        BUS_PULSE,
        BUS_HOLD
    } bus_st_e;

    bus_st_e       st, nx;
    logic [CW-1:0] cnt;
    logic          rs_q, rw_q, ctl_q;
    logic [7:0]    data_q, rd_q;

    always_comb begin
        nx = st;
        unique case (st)
            BUS_IDLE:  if (start) nx = BUS_SETUP;
            BUS_SETUP: nx = BUS_PULSE;
            BUS_PULSE: if (cnt == '0) nx = BUS_HOLD;
            BUS_HOLD:  nx = BUS_IDLE;
            default:   nx = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= BUS_IDLE;
        else        st <= nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q   <= 1'b0;
            rw_q   <= 1'b0;
            ctl_q  <= 1'b0;
            data_q <= '0;
            rd_q   <= '0;
            cnt    <= '0;
        end else begin
            if (st == BUS_IDLE && start) begin
                rs_q   <= cmd_rs;
                rw_q   <= cmd_rw;
                ctl_q  <= cmd_ctl;
                data_q <= cmd_data;
            end
            if (st == BUS_SETUP) cnt <= CW'(E_HIGH_CLKS - 1);
            if (st == BUS_PULSE) begin
                if (cnt != '0) cnt <= cnt - 1'b1;
                else           rd_q <= bus_din;
            end
        end
    end

    always_comb begin
        bus_rs   = rs_q;
        bus_rw   = rw_q;
        bus_dout = data_q;
        bus_doe  = (st != BUS_IDLE) && !rw_q;
        bus_e0   = (st == BUS_PULSE) && !ctl_q;
        bus_e1   = (st == BUS_PULSE) && ctl_q;
        done     = (st == BUS_HOLD);
        rd_data  = rd_q;
    end

    logic          e_any;
    logic [CW:0]   hi_cnt;
    assign e_any = bus_e0 | bus_e1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hi_cnt <= '0;
        else if (e_any) hi_cnt <= hi_cnt + 1'b1;
        else            hi_cnt <= '0;
    end

    a_r2_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_e0 && bus_e1));

    a_r6_setup_before_e: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(e_any) |-> ($stable(bus_rs) && $stable(bus_rw) && $stable(bus_dout)));

    a_r6_hold_after_e: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(e_any) |-> ($stable(bus_rs) && $stable(bus_rw) && $stable(bus_dout)
                          && (bus_doe == !bus_rw)));

    a_r6_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(e_any) |-> (hi_cnt == (CW+1)'(E_HIGH_CLKS)));

endmodule

// File: rtl/lcd_pos_writer.sv
module lcd_pos_writer
    import lcd_pos_pkg::*;
#(
    parameter int unsigned ROW_W       = 3,
    parameter int unsigned COL_W       = 6,
    parameter int unsigned E_HIGH_CLKS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic [7:0]       req_char,
    input  logic [1:0]       width_sel,
    output logic             req_err,
    output logic             op_done,
    output logic             lcd_rs,
    output logic             lcd_rw,
    output logic             lcd_en0,
    output logic             lcd_en1,
    output logic [7:0]       lcd_dout,
    output logic             lcd_doe,
    input  logic [7:0]       lcd_din
);
    typedef enum logic [2:0] {
        S_IDLE,
        S_SET_ADDR,
        S_POLL_ADDR,
        S_PUT_CHAR,
        S_POLL_CHAR,
        S_FINISH
    } seq_st_e;

    seq_st_e            st, nx;
    logic               launched, err_q, accept;
    logic [DISP_AW-1:0] addr_q;
    logic [7:0]         char_q;
    logic               ctl_q;

    logic               map_ok, map_ctl;
    logic [DISP_AW-1:0] map_addr;

    logic               eng_start, eng_done, eng_rs, eng_rw;
    logic [7:0]         eng_data, eng_rd;
    logic               busy_bit, unused_ac;

    lcd_addr_map #(.ROW_W(ROW_W), .COL_W(COL_W)) u_map (
        .row     (req_row),
        .col     (req_col),
        .wsel    (width_sel),
        .pos_ok  (map_ok),
        .addr    (map_addr),
        .ctl_sel (map_ctl)
    );

    lcd_bus_engine #(.E_HIGH_CLKS(E_HIGH_CLKS)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (eng_start),
        .cmd_rs   (eng_rs),
        .cmd_rw   (eng_rw),
        .cmd_data (eng_data),
        .cmd_ctl  (ctl_q),
        .done     (eng_done),
        .rd_data  (eng_rd),
        .bus_rs   (lcd_rs),
        .bus_rw   (lcd_rw),
        .bus_e0   (lcd_en0),
        .bus_e1   (lcd_en1),
        .bus_dout (lcd_dout),
        .bus_doe  (lcd_doe),
        .bus_din  (lcd_din)
    );

    assign busy_bit  = eng_rd[7];
    assign unused_ac = ^eng_rd[6:0];
    assign accept    = req_valid && req_ready;

    always_comb begin
        nx = st;
        unique case (st)
            S_IDLE:      if (accept && map_ok) nx = S_SET_ADDR;
            S_SET_ADDR:  if (eng_done) nx = S_POLL_ADDR;
            S_POLL_ADDR: if (eng_done && !busy_bit) nx = S_PUT_CHAR;
            S_PUT_CHAR:  if (eng_done) nx = S_POLL_CHAR;
            S_POLL_CHAR: if (eng_done && !busy_bit) nx = S_FINISH;
            S_FINISH:    nx = S_IDLE;
            default:     nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            launched <= 1'b0;
            err_q    <= 1'b0;
            addr_q   <= '0;
            char_q   <= '0;
            ctl_q    <= 1'b0;
        end else begin
            err_q <= accept && !map_ok;
            if (accept && map_ok) begin
                addr_q <= map_addr;
                char_q <= req_char;
                ctl_q  <= map_ctl;
            end
            if (eng_done)       launched <= 1'b0;
            else if (eng_start) launched <= 1'b1;
        end
    end

    always_comb begin
        req_ready = 1'b0;
        op_done   = 1'b0;
        eng_start = 1'b0;
        eng_rs    = 1'b0;
        eng_rw    = 1'b0;
        eng_data  = '0;
        unique case (st)
            S_IDLE:      req_ready = 1'b1;
            S_SET_ADDR: begin
                eng_start = !launched;
                eng_data  = SET_ADDR_OP | {1'b0, addr_q};
            end
            S_POLL_ADDR, S_POLL_CHAR: begin
                eng_start = !launched;
                eng_rw    = 1'b1;
            end
            S_PUT_CHAR: begin
                eng_start = !launched;
                eng_rs    = 1'b1;
                eng_data  = char_q;
            end
            S_FINISH:    op_done = 1'b1;
            default:     req_ready = 1'b0;
        endcase
        req_err = err_q;
    end

    logic e_any;
    assign e_any = lcd_en0 | lcd_en1;

    a_r8_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !e_any);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);

    a_r7_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (req_ready && !e_any && !op_done));

    a_r3_addr_instr: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SET_ADDR && e_any) |-> (!lcd_rs && !lcd_rw && lcd_dout[7] && lcd_doe));

    a_r4_poll_read: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == S_POLL_ADDR || st == S_POLL_CHAR) && e_any) |-> (!lcd_rs && lcd_rw && !lcd_doe));

    a_r5_char_write: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PUT_CHAR && e_any) |-> (lcd_rs && !lcd_rw && lcd_doe));

    a_r4_char_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_PUT_CHAR && $past(st) == S_POLL_ADDR) |-> !busy_bit);

endmodule

// File: tb/lcd_pos_writer_test.sv
module lcd_pos_writer_test;
    localparam int CLK_PERIOD = 10;
    localparam int EH         = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [2:0] req_row = '0;
    logic [5:0] req_col = '0;
    logic [7:0] req_char = '0;
    logic [1:0] width_sel = '0;
    logic       req_err, op_done;
    logic       lcd_rs, lcd_rw, lcd_en0, lcd_en1, lcd_doe;
    logic [7:0] lcd_dout, lcd_din;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_pos_writer #(.ROW_W(3), .COL_W(6), .E_HIGH_CLKS(EH)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_row(req_row), .req_col(req_col), .req_char(req_char),
        .width_sel(width_sel), .req_err(req_err), .op_done(op_done),
        .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_en0(lcd_en0), .lcd_en1(lcd_en1),
        .lcd_dout(lcd_dout), .lcd_doe(lcd_doe), .lcd_din(lcd_din)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // display model
    logic [6:0] ac = '0;
    int  busy_left = 0;
    int  b_first = 0, b_second = 0, wr_n = 0;
    assign lcd_din = {(busy_left != 0), ac};

    // transaction log, recorded at the hold clock
    int         log_n = 0;
    logic       lg_rs[0:63], lg_rw[0:63], lg_ctl[0:63], lg_busy[0:63];
    logic [7:0] lg_dat[0:63];
    int         lg_hi[0:63];
    logic       pe0 = 1'b0, pe1 = 1'b0;
    int         hi = 0;

    always @(negedge clk) begin
        if (lcd_en0 || lcd_en1) hi++;
        if ((pe0 || pe1) && !(lcd_en0 || lcd_en1)) begin
            if (log_n < 64) begin
                lg_rs[log_n]  = lcd_rs;
                lg_rw[log_n]  = lcd_rw;
                lg_dat[log_n] = lcd_dout;
                lg_ctl[log_n] = pe1;
                lg_hi[log_n]  = hi;
                lg_busy[log_n] = (busy_left != 0);
            end
            log_n++;
            if (!lcd_rw) begin
                if (!lcd_rs) ac = lcd_dout[6:0];
                else         ac = ac + 7'd1;
                busy_left = (wr_n == 0) ? b_first : b_second;
                wr_n++;
            end else if (busy_left > 0) begin
                busy_left--;
            end
            hi = 0;
        end
        pe0 = lcd_en0;
        pe1 = lcd_en1;
    end

    // expected map: {ok, ctl, addr[6:0]}
    function automatic logic [8:0] exp_map(input int row, input int col, input int w);
        int lim;
        int base;
        logic ctl;
        lim = (w == 0) ? 16 : (w == 1) ? 20 : (w == 2) ? 40 : 0;
        if (row > 3 || col >= lim) return 9'd0;
        ctl = 1'b0;
        if (w == 2) begin
            base = (row % 2 == 1) ? 'h40 : 'h00;
            ctl  = (row >= 2);
        end else begin
            case (row)
                0: base = 'h00;
                1: base = 'h40;
                2: base = 'h14;
                default: base = 'h54;
            endcase
        end
        return {1'b1, ctl, 7'(base + col)};
    endfunction

    task automatic run_req(input int row, input int col, input int ch, input int w,
                           input int b1, input int b2);
        logic [8:0] m;
        int cyc;
        int n_exp;
        int idx;
        m = exp_map(row, col, w);
        @(negedge clk);
        log_n = 0; wr_n = 0; b_first = b1; b_second = b2;
        req_row = 3'(row); req_col = 6'(col); req_char = 8'(ch); width_sel = 2'(w);
        req_valid = 1'b1;
        chk(req_ready == 1'b1, "R8 ready before request", int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        if (!m[8]) begin
            chk(req_err == 1'b1, "R7 error pulse", int'(req_err), 1);
            @(negedge clk);
            chk(req_err == 1'b0, "R7 error one clock", int'(req_err), 0);
            repeat (EH + 4) @(negedge clk);
            chk(log_n == 0, "R7 no bus activity", log_n, 0);
            chk(req_ready == 1'b1 && op_done == 1'b0, "R7 stays idle", int'(req_ready), 1);
            return;
        end
        chk(req_err == 1'b0, "R7 no error for valid", int'(req_err), 0);
        chk(req_ready == 1'b0, "R8 not ready when busy", int'(req_ready), 0);
        cyc = 0;
        while (!op_done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        n_exp = 4 + b1 + b2;
        chk(cyc == n_exp * (EH + 3), "R8 done timing", cyc, n_exp * (EH + 3));
        chk(log_n == n_exp, "R4 transaction count", log_n, n_exp);
        if (log_n == n_exp) begin
            for (int i = 0; i < n_exp; i++) begin
                chk(lg_ctl[i] == m[7], (m[7] || w == 2) ? "R2 enable select" : "R1 enable select",
                    int'(lg_ctl[i]), int'(m[7]));
                chk(lg_hi[i] == EH, "R6 enable width", lg_hi[i], EH);
            end
            chk(!lg_rs[0] && !lg_rw[0], "R3 instruction type", {lg_rs[0], lg_rw[0]}, 0);
            chk(lg_dat[0] == (8'h80 | {1'b0, m[6:0]}), (w == 2) ? "R2 address" : "R1 address",
                int'(lg_dat[0]), int'(8'h80 | {1'b0, m[6:0]}));
            for (int i = 1; i <= b1 + 1; i++) begin
                chk(!lg_rs[i] && lg_rw[i], "R4 poll after address", {lg_rs[i], lg_rw[i]}, 1);
                chk(lg_busy[i] == (i <= b1), "R4 busy sequence", int'(lg_busy[i]), int'(i <= b1));
            end
            idx = b1 + 2;
            chk(lg_rs[idx] && !lg_rw[idx], "R5 data write type", {lg_rs[idx], lg_rw[idx]}, 2);
            chk(lg_dat[idx] == 8'(ch), "R5 character", int'(lg_dat[idx]), ch);
            for (int i = idx + 1; i < n_exp; i++)
                chk(!lg_rs[i] && lg_rw[i], "R4 poll after character", {lg_rs[i], lg_rw[i]}, 1);
            chk(!lg_busy[n_exp-1], "R4 final poll idle", int'(lg_busy[n_exp-1]), 0);
        end
        @(negedge clk);
        chk(op_done == 1'b0 && req_ready == 1'b1, "R8 done one clock", int'(op_done), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", total, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && !lcd_en0 && !lcd_en1 && !req_err && !op_done && !lcd_doe,
            "R8 reset state", {req_ready, lcd_en0, lcd_en1, req_err, op_done, lcd_doe}, 32);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && !lcd_en0 && !lcd_en1, "R8 idle after reset", int'(req_ready), 1);

        run_req(0, 0, 'h41, 0, 0, 0);
        run_req(2, 0, 'h42, 0, 1, 0);
        run_req(3, 15, 'h43, 0, 0, 2);
        run_req(3, 19, 'h44, 1, 2, 1);
        run_req(1, 19, 'h45, 1, 0, 0);
        run_req(0, 39, 'h46, 2, 0, 1);
        run_req(1, 39, 'h47, 2, 1, 1);
        run_req(2, 0, 'h48, 2, 0, 0);
        run_req(3, 39, 'h49, 2, 5, 3);
        run_req(0, 16, 'h4A, 0, 0, 0);
        run_req(1, 20, 'h4B, 1, 0, 0);
        run_req(2, 40, 'h4C, 2, 0, 0);
        run_req(4, 0, 'h4D, 0, 0, 0);
        run_req(7, 3, 'h4E, 2, 0, 0);
        run_req(0, 0, 'h4F, 3, 0, 0);
        for (int k = 0; k < 60; k++) begin
            run_req(int'($urandom % 5), int'($urandom % 44), int'($urandom % 256),
                    int'($urandom % 4), int'($urandom % 4), int'($urandom % 4));
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule